// File: doc/BRIEF.md
# Fringe-Windowed Distinct-Count Bitmap Store

This block holds the bitmap state of a stochastic-averaging distinct-value sketch in compressed form. Each bucket keeps a narrow window of its logical 32-bit bitmap instead of the whole thing. One offset, shared by every bucket, says which logical bit the bottom of each window stands for. An upstream hash stage supplies updates as a bucket index and a run length. The block sets the matching logical bit when that bit falls inside the window. A run length below the offset is already implied to be set, so it is ignored. A run length above the window cannot be stored; it is dropped and counted as a truncation event.

A population counter tracks how many buckets have their bottom window bit set. When all of them do, the window slides up one logical position: every window shifts right by one and the offset increments. This repeats once per cycle for as long as the condition holds, and the update port stalls while it does. The offset stops where the window's top reaches the last logical bit.

On request, a scan walks all buckets. It adds up, for each bucket, the offset plus the index of the lowest clear bit in its window, and reports the total. A downstream stage turns that total into a cardinality. A synchronous clear empties the whole sketch.

Top module: `fringe_sketch_store`

## Requirements
- R1: After reset, `offset` is 0, `trunc_count` is 0, `upd_ready` is 1, and an estimate scan returns 0.
- R2: An accepted update (`upd_valid` and `upd_ready` both high) with `offset <= upd_run < offset + WIN_W` sets window bit `upd_run - offset` of bucket `upd_idx` only. Window bit 0 is the lowest logical position held.
- R3: An accepted update with `upd_run < offset` changes no window, does not move the offset, and leaves `trunc_count` unchanged.
- R4: An accepted update with `upd_run >= offset + WIN_W` changes no window and adds 1 to `trunc_count`, which saturates at all ones.
- R5: While every bucket has window bit 0 set and `offset < FULL_W - WIN_W`, one step per cycle shifts each window right by one (zero entering at the top) and increments `offset` by 1. The offset never changes otherwise, except on clear.
- R6: `upd_ready` is low exactly in the cycles in which a window step is pending, and an update offered then is not taken.
- R7: `offset` never exceeds `FULL_W - WIN_W`. At that value, full bottom bits cause no step and `upd_ready` stays high.
- R8: A pulse on `est_start` while idle starts a scan. `est_busy` is high for NUM_MAPS cycles, then `est_done` pulses for one cycle with `est_sum` equal to the sum over buckets of `offset` plus the lowest clear window bit index (WIN_W for a full window).
- R9: A cycle with `clear` high empties every window, sets `offset` and `trunc_count` to 0, and aborts any scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous sketch clear |
| upd_valid | input | 1 | Update offered |
| upd_idx | input | IDX_W | Bucket index of the update |
| upd_run | input | RUN_W | Logical bit position (run length) of the update |
| upd_ready | output | 1 | Update can be taken this cycle |
| est_start | input | 1 | Start an estimate scan |
| est_busy | output | 1 | Scan in progress |
| est_done | output | 1 | One-cycle pulse, scan result valid |
| est_sum | output | SUM_W | Sum of per-bucket lowest-zero logical positions |
| offset | output | RUN_W | Shared logical position of window bit 0 |
| trunc_count | output | TRUNC_W | Saturating count of dropped updates |

## Verification
The bench aims at the window edges. A run one above the window top must count as a drop and leave the estimate alone; an off-by-one compare would store it instead. A run one below the offset must be ignored silently; a design that stores it or counts it as a drop fails the truncation and estimate checks. The advance chain matters too. A design that reloads the population count wrongly after a step either stalls forever or slides past buckets whose next bit is clear, and that shows as a wrong offset. A design without the offset cap walks the window off the top of the logical bitmap, and the 128-count full-window estimate catches it. The bench also checks the one-cycle stall, saturation of the truncation counter, and that a clear also empties that counter.

// File: rtl/fringe_pkg.sv
// Shared types for the fringe-windowed bitmap store.
package fringe_pkg;

    // Outcome of one offered update against the current window.
    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,  // nothing accepted this cycle
        UPD_BELOW = 2'd1,  // run below the offset: implied set, ignored
        UPD_STORE = 2'd2,  // run inside the window: set a bit
        UPD_DROP  = 2'd3   // run above the window: truncation event
    } upd_kind_e;

endpackage

// File: rtl/fringe_classify.sv
// Classifies an accepted update against the shared offset.
// Assumes WIN_W < 2**RUN_W, so a window position fits in the run width.
module fringe_classify
    import fringe_pkg::*;
#(
    parameter int RUN_W = 5,
    parameter int WIN_W = 12,
    parameter int POS_W = 4
) (
    input  logic             take,
    input  logic [RUN_W-1:0] run,
    input  logic [RUN_W-1:0] base,
    output upd_kind_e        kind,
    output logic [POS_W-1:0] pos
);
    localparam logic [RUN_W:0] WIN_L = (RUN_W+1)'(WIN_W);

    logic [RUN_W-1:0] rel;

    // Relative position and the class of the update.
    always_comb begin
        rel = run - base;
        pos = rel[POS_W-1:0];
        if (!take)
            kind = UPD_IDLE;
        else if (run < base)
            kind = UPD_BELOW;
        else if ({1'b0, rel} >= WIN_L)
            kind = UPD_DROP;
        else
            kind = UPD_STORE;
    end
endmodule

// File: rtl/fringe_bank.sv
// Window storage: one WIN_W-bit window per bucket.
// A step shifts every window right by one; a write sets one bit.
// Assumes step and write never fall in the same cycle (the top stalls writes).
module fringe_bank #(
    parameter int NUM_MAPS = 16,
    parameter int WIN_W    = 12,
    parameter int IDX_W    = 4,
    parameter int POS_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      step,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [POS_W-1:0]          wr_pos,
    output logic [NUM_MAPS*WIN_W-1:0] maps_flat,
    output logic [NUM_MAPS-1:0]       bottom_col,
    output logic [NUM_MAPS-1:0]       next_col
);
    for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
        logic [WIN_W-1:0] win;

        // Hold, clear, slide or set one bucket window.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                win <= '0;
            else if (step)
                win <= win >> 1;
            else if (wr_en && wr_idx == IDX_W'(g))
                win[wr_pos] <= 1'b1;
        end

        assign maps_flat[g*WIN_W +: WIN_W] = win;
        assign bottom_col[g] = win[0];
        assign next_col[g]   = win[1];
    end
endmodule

// File: rtl/fringe_colcount.sv
// Counts the set bits of one bit column across all buckets.
module fringe_colcount #(
    parameter int N     = 16,
    parameter int CNT_W = 5
) (
    input  logic [N-1:0]     col,
    output logic [CNT_W-1:0] cnt
);
    // Plain adder chain; the tool balances it.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++)
            cnt = cnt + CNT_W'(col[i]);
    end
endmodule

// File: rtl/fringe_lowzero.sv
// Index of the lowest clear bit of a window, WIN_W when the window is full.
module fringe_lowzero #(
    parameter int WIN_W = 12,
    parameter int LZ_W  = 4
) (
    input  logic [WIN_W-1:0] win,
    output logic [LZ_W-1:0]  lz
);
    // Scan from the top so the lowest clear bit wins.
    always_comb begin
        lz = LZ_W'(WIN_W);
        for (int i = WIN_W - 1; i >= 0; i--)
            if (!win[i])
                lz = LZ_W'(i);
    end
endmodule

// File: rtl/fringe_scan.sv
// Estimate sequencer: one bucket per cycle, adds offset plus lowest zero.
// Assumes NUM_MAPS >= 2. A step during a scan keeps each bucket term unchanged,
// because a step needs bit 0 set, so the lowest zero drops by one as the offset rises.
module fringe_scan #(
    parameter int NUM_MAPS = 16,
    parameter int WIN_W    = 12,
    parameter int RUN_W    = 5,
    parameter int IDX_W    = 4,
    parameter int LZ_W     = 4,
    parameter int SUM_W    = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      start,
    input  logic [NUM_MAPS*WIN_W-1:0] maps_flat,
    input  logic [RUN_W-1:0]          base,
    output logic                      busy,
    output logic                      done,
    output logic [SUM_W-1:0]          sum
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_MAPS - 1);

    logic [IDX_W-1:0] idx;
    logic [SUM_W-1:0] acc;
    logic [WIN_W-1:0] cur;
    logic [LZ_W-1:0]  lz;
    logic [RUN_W:0]   term;

    assign cur  = maps_flat[idx*WIN_W +: WIN_W];
    assign term = {1'b0, base} + (RUN_W+1)'(lz);

    fringe_lowzero #(.WIN_W(WIN_W), .LZ_W(LZ_W)) u_lz (
        .win (cur),
        .lz  (lz)
    );

    // Walk the buckets and accumulate their terms.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            busy <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
            acc  <= '0;
            sum  <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                acc <= acc + SUM_W'(term);
                if (idx == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    sum  <= acc + SUM_W'(term);
                end else begin
                    idx <= idx + 1'b1;
                end
            end else if (start) begin
                busy <= 1'b1;
                idx  <= '0;
                acc  <= '0;
            end
        end
    end
endmodule

// File: rtl/fringe_sketch_store.sv
// Top: fringe-windowed bitmap store with shared offset, truncation
// counting, left-truncation window steps and an estimate scan.
// Assumes WIN_W >= 2, WIN_W < FULL_W, NUM_MAPS >= 2, FULL_W a power of two.
module fringe_sketch_store
    import fringe_pkg::*;
#(
    parameter int NUM_MAPS = 16,
    parameter int WIN_W    = 12,
    parameter int FULL_W   = 32,
    parameter int TRUNC_W  = 16,
    localparam int IDX_W   = $clog2(NUM_MAPS),
    localparam int RUN_W   = $clog2(FULL_W),
    localparam int SUM_W   = $clog2(NUM_MAPS * FULL_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               upd_valid,
    input  logic [IDX_W-1:0]   upd_idx,
    input  logic [RUN_W-1:0]   upd_run,
    output logic               upd_ready,
    input  logic               est_start,
    output logic               est_busy,
    output logic               est_done,
    output logic [SUM_W-1:0]   est_sum,
    output logic [RUN_W-1:0]   offset,
    output logic [TRUNC_W-1:0] trunc_count
);
    localparam int POS_W = $clog2(WIN_W);
    localparam int LZ_W  = $clog2(WIN_W + 1);
    localparam int CNT_W = $clog2(NUM_MAPS + 1);
    localparam logic [RUN_W-1:0] MAX_OFF  = RUN_W'(FULL_W - WIN_W);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_MAPS);

    upd_kind_e                 kind;
    logic [POS_W-1:0]          pos;
    logic                      step;
    logic                      take;
    logic [CNT_W-1:0]          pop;
    logic [CNT_W-1:0]          next_cnt;
    logic [NUM_MAPS*WIN_W-1:0] maps_flat;
    logic [NUM_MAPS-1:0]       bottom_col;
    logic [NUM_MAPS-1:0]       next_col;

    // A step is pending when every bottom bit is set and there is room to slide.
    assign step      = !clear && (pop == FULL_CNT) && (offset < MAX_OFF);
    assign upd_ready = !step;
    assign take      = upd_valid && upd_ready && !clear;

    fringe_classify #(.RUN_W(RUN_W), .WIN_W(WIN_W), .POS_W(POS_W)) u_cls (
        .take (take),
        .run  (upd_run),
        .base (offset),
        .kind (kind),
        .pos  (pos)
    );

    fringe_bank #(
        .NUM_MAPS (NUM_MAPS),
        .WIN_W    (WIN_W),
        .IDX_W    (IDX_W),
        .POS_W    (POS_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .step       (step),
        .wr_en      (kind == UPD_STORE),
        .wr_idx     (upd_idx),
        .wr_pos     (pos),
        .maps_flat  (maps_flat),
        .bottom_col (bottom_col),
        .next_col   (next_col)
    );

    fringe_colcount #(.N(NUM_MAPS), .CNT_W(CNT_W)) u_cnt (
        .col (next_col),
        .cnt (next_cnt)
    );

    // Population of set bottom bits: +1 on a fresh bottom write, reload on a step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            pop <= '0;
        else if (step)
            pop <= next_cnt;
        else if (kind == UPD_STORE && pos == '0 && !bottom_col[upd_idx])
            pop <= pop + 1'b1;
    end

    // Shared offset advances by one on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            offset <= '0;
        else if (step)
            offset <= offset + 1'b1;
    end

    // Saturating truncation-event counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            trunc_count <= '0;
        else if (kind == UPD_DROP && trunc_count != '1)
            trunc_count <= trunc_count + 1'b1;
    end

    fringe_scan #(
        .NUM_MAPS (NUM_MAPS),
        .WIN_W    (WIN_W),
        .RUN_W    (RUN_W),
        .IDX_W    (IDX_W),
        .LZ_W     (LZ_W),
        .SUM_W    (SUM_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .start     (est_start),
        .maps_flat (maps_flat),
        .base      (offset),
        .busy      (est_busy),
        .done      (est_done),
        .sum       (est_sum)
    );
endmodule

// File: rtl/fringe_sketch_chk.sv
// Port-level checker for fringe_sketch_store, attached by bind.
module fringe_sketch_chk #(
    parameter int NUM_MAPS = 16,
    parameter int WIN_W    = 12,
    parameter int FULL_W   = 32,
    parameter int TRUNC_W  = 16,
    localparam int IDX_W   = $clog2(NUM_MAPS),
    localparam int RUN_W   = $clog2(FULL_W),
    localparam int SUM_W   = $clog2(NUM_MAPS * FULL_W + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clear,
    input logic               upd_valid,
    input logic [IDX_W-1:0]   upd_idx,
    input logic [RUN_W-1:0]   upd_run,
    input logic               upd_ready,
    input logic               est_start,
    input logic               est_busy,
    input logic               est_done,
    input logic [SUM_W-1:0]   est_sum,
    input logic [RUN_W-1:0]   offset,
    input logic [TRUNC_W-1:0] trunc_count
);
    localparam logic [RUN_W-1:0] MAX_OFF = RUN_W'(FULL_W - WIN_W);

    AST_OFF_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        offset <= MAX_OFF);  // R7

    AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (offset == $past(offset) || offset == $past(offset) + 1'b1));  // R5

    AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_ready && !clear) |=> offset == $past(offset) + 1'b1);  // R6

    AST_TRUNC_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> trunc_count >= $past(trunc_count));  // R4

    AST_BELOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_ready && !clear && upd_run < offset)
        |=> (trunc_count == $past(trunc_count) && offset == $past(offset)));  // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        est_done |=> !est_done);  // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        est_done |-> !est_busy);  // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (offset == '0 && trunc_count == '0 && !est_busy));  // R9
endmodule

bind fringe_sketch_store fringe_sketch_chk #(
    .NUM_MAPS (NUM_MAPS),
    .WIN_W    (WIN_W),
    .FULL_W   (FULL_W),
    .TRUNC_W  (TRUNC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .upd_valid   (upd_valid),
    .upd_idx     (upd_idx),
    .upd_run     (upd_run),
    .upd_ready   (upd_ready),
    .est_start   (est_start),
    .est_busy    (est_busy),
    .est_done    (est_done),
    .est_sum     (est_sum),
    .offset      (offset),
    .trunc_count (trunc_count)
);

// File: tb/tb_fringe_sketch_store.sv
// Bench: vector table walk, then directed reset and corner tests.
module tb_fringe_sketch_store;
    localparam int NM = 4;
    localparam int WW = 12;
    localparam int FW = 32;
    localparam int TW = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       upd_valid = 1'b0;
    logic [1:0] upd_idx = '0;
    logic [4:0] upd_run = '0;
    logic       upd_ready;
    logic       est_start = 1'b0;
    logic       est_busy;
    logic       est_done;
    logic [7:0] est_sum;
    logic [4:0] offset;
    logic [2:0] trunc_count;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fringe_sketch_store #(.NUM_MAPS(NM), .WIN_W(WW), .FULL_W(FW), .TRUNC_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_run(upd_run),
        .upd_ready(upd_ready), .est_start(est_start), .est_busy(est_busy),
        .est_done(est_done), .est_sum(est_sum), .offset(offset),
        .trunc_count(trunc_count)
    );

    // Stimulus row: bucket, run, expected offset and truncation count after settling.
    typedef struct packed {
        logic [1:0] idx;
        logic [4:0] run;
        logic [4:0] exp_off;
        logic [2:0] exp_tr;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{2'd0, 5'd0,  5'd0, 3'd0},   // R2 store bit 0
        '{2'd1, 5'd0,  5'd0, 3'd0},
        '{2'd2, 5'd0,  5'd0, 3'd0},
        '{2'd3, 5'd0,  5'd1, 3'd0},   // R5 all bottoms set -> one step
        '{2'd0, 5'd0,  5'd1, 3'd0},   // R3 below offset, ignored
        '{2'd0, 5'd13, 5'd1, 3'd1},   // R4 one past window top, dropped
        '{2'd1, 5'd12, 5'd1, 3'd1},   // R2 window top bit stored
        '{2'd0, 5'd1,  5'd1, 3'd1},
        '{2'd1, 5'd1,  5'd1, 3'd1},
        '{2'd2, 5'd1,  5'd1, 3'd1},
        '{2'd3, 5'd2,  5'd1, 3'd1},
        '{2'd3, 5'd1,  5'd2, 3'd1}    // R5 step stops where next column is not full
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_upd(input int idx, input int run);
        @(negedge clk);
        while (!upd_ready) @(negedge clk);
        upd_valid = 1'b1;
        upd_idx   = 2'(idx);
        upd_run   = 5'(run);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic estimate(output int val);
        @(negedge clk);
        est_start = 1'b1;
        @(negedge clk);
        est_start = 1'b0;
        while (!est_done) @(negedge clk);
        val = int'(est_sum);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 offset", int'(offset), 0);
        chk("R1 trunc", int'(trunc_count), 0);
        chk("R1 ready", int'(upd_ready), 1);
        estimate(e);
        chk("R1 estimate", e, 0);

        // R6 one-cycle stall when the last bottom bit fills
        for (int m = 0; m < NM; m++) do_upd(m, 0);
        chk("R6 ready low while step pending", int'(upd_ready), 0);
        @(negedge clk);
        chk("R6 ready back high", int'(upd_ready), 1);
        chk("R5 offset after step", int'(offset), 1);

        // Table walk
        do_clear();
        for (int i = 0; i < 12; i++) begin
            do_upd(int'(VEC[i].idx), int'(VEC[i].run));
            repeat (3) @(negedge clk);
            chk($sformatf("R5 row %0d offset", i), int'(offset), int'(VEC[i].exp_off));
            chk($sformatf("R4 row %0d trunc", i), int'(trunc_count), int'(VEC[i].exp_tr));
        end
        estimate(e);
        chk("R8 table estimate", e, 9);

        // R2 only the addressed bucket changes
        do_clear();
        do_upd(2, 0);
        do_upd(2, 1);
        estimate(e);
        chk("R2 bucket two low run", e, 2);
        do_upd(1, 3);
        estimate(e);
        chk("R2 gap bit leaves lowest zero", e, 2);

        // R7 offset cap, full windows
        do_clear();
        for (int r = 0; r < FW; r++)
            for (int m = 0; m < NM; m++) do_upd(m, r);
        repeat (3) @(negedge clk);
        chk("R7 offset capped", int'(offset), FW - WW);
        chk("R7 ready high at cap", int'(upd_ready), 1);
        estimate(e);
        chk("R8 full-window estimate", e, NM * FW);

        // R4 saturation
        do_clear();
        for (int k = 0; k < 9; k++) do_upd(0, 20);
        chk("R4 trunc saturates", int'(trunc_count), 7);
        estimate(e);
        chk("R4 drops leave windows empty", e, 0);

        // R9 clear empties everything
        do_clear();
        chk("R9 trunc cleared", int'(trunc_count), 0);
        chk("R9 offset cleared", int'(offset), 0);
        estimate(e);
        chk("R9 estimate cleared", e, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule